// File: doc/BRIEF.md
# Burst Acquisition Mode Scheduler

This block paces the measurement bursts of a capacitive touch sensor front end. Between bursts it waits for a number of microsecond ticks. The count depends on the acquisition mode. When the switched output is on, or when a touch is suspected but not yet settled, the scheduler uses the short fast-mode gap. Otherwise it uses the long low-power sleep. A verdict input ends the suspicion. A rejected touch drops the scheduler back to low-power pacing. A confirmed touch keeps fast pacing until the output turns on, and the output then holds fast pacing by itself.

During a burst the scheduler drives alternating charge and transfer phase enables, starting with charge. Each phase lasts a nominal number of clock cycles, shifted by a pseudo-random offset of at most 7.5 percent of the nominal length, so that burst emissions spread over a band. The burst lasts until the measurement logic returns its end strobe. An inhibit input holds off any new burst while it is high.

Top module: `burst_sched`

## Requirements
- R1: After reset, burstStart, chargeEn and xferEn are low, and the first burst starts only after the gap of the current mode has been counted.
- R2: While outOn is high, a burst starts on the first clock in which at least FAST_GAP_US usTick pulses have been counted since the burst-end strobe; a tick in the same cycle as the strobe is not counted.
- R3: While outOn is low and no touch is suspected, the gap is SLOW_GAP_US ticks, counted the same way.
- R4: A maybeTouch pulse while outOn is low switches to the fast gap from the next cycle, which also shortens a sleep already in progress.
- R5: A touchDeny pulse ends the suspicion and low-power pacing resumes; touchDeny wins over a maybeTouch or touchConfirm in the same cycle.
- R6: A touchConfirm pulse while outOn is low keeps fast pacing; once outOn is high, the suspicion is cleared and outOn alone sets the mode.
- R7: No burst starts while inhibit is high; after inhibit falls with the gap already counted, the burst starts at the next clock.
- R8: burstStart is a one-cycle pulse in the first cycle of charge; charge and transfer phases alternate, charge first, and are never enabled together.
- R9: Every phase that ends by switching to the other phase lasts between PHASE_CYCLES-D and PHASE_CYCLES+D cycles, D = floor(PHASE_CYCLES*75/1000), and the lengths vary from phase to phase.
- R10: A burstDone strobe during a burst drops both enables from the next cycle; burstDone outside a burst has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| outOn | input | 1 | Switched output is in its active state |
| maybeTouch | input | 1 | Pulse: a possible touch was seen |
| touchConfirm | input | 1 | Pulse: the suspected touch was confirmed |
| touchDeny | input | 1 | Pulse: the suspected touch was rejected |
| burstDone | input | 1 | Pulse: the measurement burst is finished |
| inhibit | input | 1 | Hold off new bursts while high |
| usTick | input | 1 | One-cycle pulse per microsecond |
| burstStart | output | 1 | One-cycle pulse at the start of a burst |
| chargeEn | output | 1 | Charge phase enable |
| xferEn | output | 1 | Transfer phase enable |

## Verification
The scheduler is run with the output off and nothing suspected, then with the output on, to separate the two gap lengths. A possible touch arrives partway through a sleep, which shows that the mode changes at once and not at the next burst. A rejection and a confirmation then follow, and each has a different effect on later gaps. Inhibit is held across a gap that has already finished counting, and stray burst-end strobes arrive during a gap, to show that neither the start nor the count is disturbed. Phase lengths are collected over all bursts, which checks both the dither bound and that the dither is really applied.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;

  typedef enum logic [1:0] {
    ST_GAP    = 2'd0,
    ST_CHARGE = 2'd1,
    ST_XFER   = 2'd2
  } schedState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic gapClr;     // restart the inter-burst tick count
    logic phaseLoad;  // load a freshly dithered phase length
  } dpCtrl_t;

endpackage

// File: rtl/burst_sched_dpath.sv
module burst_sched_dpath
  import burst_sched_pkg::*;
#(
  parameter int FAST_GAP_US  = 2600,
  parameter int SLOW_GAP_US  = 85000,
  parameter int PHASE_CYCLES = 200,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    usTick,
  input  logic    fastMode,
  input  dpCtrl_t dpCtrl,
  output logic    gapReached,
  output logic    phaseEnd
);

  localparam int GAP_W      = $clog2(SLOW_GAP_US + 1);
  localparam int DITHER_MAX = (PHASE_CYCLES * 75) / 1000;
  localparam int SPAN       = 2 * DITHER_MAX + 1;
  localparam int PH_W       = $clog2(PHASE_CYCLES + DITHER_MAX + 1);
  localparam logic [GAP_W-1:0] FAST_LIM = GAP_W'(FAST_GAP_US);
  localparam logic [GAP_W-1:0] SLOW_LIM = GAP_W'(SLOW_GAP_US);
  localparam logic [PH_W-1:0]  MIN_LOAD = PH_W'(PHASE_CYCLES - DITHER_MAX - 1);
  localparam logic [PH_W-1:0]  MAX_LOAD = PH_W'(PHASE_CYCLES + DITHER_MAX - 1);

  logic [GAP_W-1:0] gapCnt;
  logic [GAP_W-1:0] gapLimit;
  logic [PH_W-1:0]  phaseCnt;
  logic [PH_W-1:0]  loadVal;
  logic [15:0]      lfsrQ;

  // gap counter: ticks since the last burst ended, held at the limit
  assign gapLimit   = fastMode ? FAST_LIM : SLOW_LIM;
  assign gapReached = (gapCnt >= gapLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (dpCtrl.gapClr) begin
      gapCnt <= '0;
    end else if (usTick && (gapCnt < gapLimit)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // free-running Galois LFSR, x^16 + x^14 + x^13 + x^11 + 1
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= LFSR_SEED;
    end else begin
      lfsrQ <= {1'b0, lfsrQ[15:1]} ^ (lfsrQ[0] ? 16'hB400 : 16'h0000);
    end
  end

  // dithered phase length (stored as length minus one)
  generate
    if (DITHER_MAX > 0) begin : g_dither
      logic [15:0] pickRaw;
      assign pickRaw = lfsrQ % 16'(SPAN);
      assign loadVal = MIN_LOAD + PH_W'(pickRaw);
    end else begin : g_fixed
      assign loadVal = PH_W'(PHASE_CYCLES - 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (dpCtrl.phaseLoad) begin
      phaseCnt <= loadVal;
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - 1'b1;
    end
  end

  assign phaseEnd = (phaseCnt == '0);

  // R9: every loaded phase length lies inside the dither window
  p_phase_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.phaseLoad |=> (phaseCnt >= MIN_LOAD) && (phaseCnt <= MAX_LOAD));

  // R2: without a tick or a restart the count does not move
  p_gap_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!usTick && !dpCtrl.gapClr) |=> $stable(gapCnt));

  // R3: the count never runs past the longest gap
  p_gap_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= SLOW_LIM);

endmodule

// File: rtl/burst_sched_ctrl.sv
module burst_sched_ctrl
  import burst_sched_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    outOn,
  input  logic    maybeTouch,
  input  logic    touchConfirm,
  input  logic    touchDeny,
  input  logic    burstDone,
  input  logic    inhibit,
  input  logic    gapReached,
  input  logic    phaseEnd,
  output logic    fastMode,
  output dpCtrl_t dpCtrl,
  output logic    burstStart,
  output logic    chargeEn,
  output logic    xferEn
);

  schedState_e stateQ, stateD;
  logic        suspectQ;
  logic        startQ;

  // suspicion of a touch forces fast pacing while the output is off
  always_ff @(posedge clk) begin
    if (!rstN) begin
      suspectQ <= 1'b0;
    end else if (touchDeny) begin
      suspectQ <= 1'b0;
    end else if (outOn) begin
      suspectQ <= 1'b0;
    end else if (maybeTouch || touchConfirm) begin
      suspectQ <= 1'b1;
    end
  end

  assign fastMode = outOn || suspectQ;

  always_comb begin
    stateD = stateQ;
    dpCtrl = '0;
    unique case (stateQ)
      ST_GAP: begin
        if (gapReached && !inhibit) begin
          stateD           = ST_CHARGE;
          dpCtrl.phaseLoad = 1'b1;
        end
      end
      ST_CHARGE, ST_XFER: begin
        if (burstDone) begin
          stateD        = ST_GAP;
          dpCtrl.gapClr = 1'b1;
        end else if (phaseEnd) begin
          stateD           = (stateQ == ST_CHARGE) ? ST_XFER : ST_CHARGE;
          dpCtrl.phaseLoad = 1'b1;
        end
      end
      default: stateD = ST_GAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_GAP;
      startQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      startQ <= (stateQ == ST_GAP) && (stateD == ST_CHARGE);
    end
  end

  assign burstStart = startQ;
  assign chargeEn   = (stateQ == ST_CHARGE);
  assign xferEn     = (stateQ == ST_XFER);

  // R7: a start needs a finished gap and no inhibit one cycle earlier
  p_start_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |-> ($past(gapReached) && !$past(inhibit)));

  // R10: the end strobe closes the burst at the next edge
  p_done_stops_r10: assert property (@(posedge clk) disable iff (!rstN)
    (burstDone && (chargeEn || xferEn)) |=> !(chargeEn || xferEn));

  // R8: a finished charge phase hands over to transfer
  p_alt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (chargeEn && phaseEnd && !burstDone) |=> xferEn);

  // R5: a rejection always clears the suspicion
  p_deny_r5: assert property (@(posedge clk) disable iff (!rstN)
    touchDeny |=> !suspectQ);

endmodule

// File: rtl/burst_sched.sv
module burst_sched
  import burst_sched_pkg::*;
#(
  parameter int FAST_GAP_US  = 2600,
  parameter int SLOW_GAP_US  = 85000,
  parameter int PHASE_CYCLES = 200,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rstN,
  input  logic outOn,
  input  logic maybeTouch,
  input  logic touchConfirm,
  input  logic touchDeny,
  input  logic burstDone,
  input  logic inhibit,
  input  logic usTick,
  output logic burstStart,
  output logic chargeEn,
  output logic xferEn
);

  dpCtrl_t dpCtrl;
  logic    fastMode;
  logic    gapReached;
  logic    phaseEnd;

  burst_sched_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .outOn        (outOn),
    .maybeTouch   (maybeTouch),
    .touchConfirm (touchConfirm),
    .touchDeny    (touchDeny),
    .burstDone    (burstDone),
    .inhibit      (inhibit),
    .gapReached   (gapReached),
    .phaseEnd     (phaseEnd),
    .fastMode     (fastMode),
    .dpCtrl       (dpCtrl),
    .burstStart   (burstStart),
    .chargeEn     (chargeEn),
    .xferEn       (xferEn)
  );

  burst_sched_dpath #(
    .FAST_GAP_US  (FAST_GAP_US),
    .SLOW_GAP_US  (SLOW_GAP_US),
    .PHASE_CYCLES (PHASE_CYCLES),
    .LFSR_SEED    (LFSR_SEED)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .usTick     (usTick),
    .fastMode   (fastMode),
    .dpCtrl     (dpCtrl),
    .gapReached (gapReached),
    .phaseEnd   (phaseEnd)
  );

endmodule

// File: tb/tb_burst_sched.sv
module tb_burst_sched;

  localparam int FAST  = 6;
  localparam int SLOW  = 20;
  localparam int PH    = 40;
  localparam int DMAX  = (PH * 75) / 1000;
  localparam int TDIV  = 2;
  localparam int BLEN  = 130;
  localparam int WDOG  = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic outOn = 1'b0, maybeTouch = 1'b0, touchConfirm = 1'b0, touchDeny = 1'b0;
  logic inhibit = 1'b0, usTick = 1'b0, autoDone = 1'b0, extraDone = 1'b0;
  logic burstDone;
  logic burstStart, chargeEn, xferEn;

  assign burstDone = autoDone | extraDone;

  always #2.5 clk = ~clk;

  burst_sched #(.FAST_GAP_US(FAST), .SLOW_GAP_US(SLOW), .PHASE_CYCLES(PH)) dut (
    .clk(clk), .rstN(rstN), .outOn(outOn), .maybeTouch(maybeTouch),
    .touchConfirm(touchConfirm), .touchDeny(touchDeny), .burstDone(burstDone),
    .inhibit(inhibit), .usTick(usTick), .burstStart(burstStart),
    .chargeEn(chargeEn), .xferEn(xferEn)
  );

  int total = 0, fails = 0, cyc = 0;
  string curReq = "R1";
  bit finished = 0;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model, updated at each rising edge
  int  mCnt = 0;
  bit  mBurst = 0, mStart = 0, mSusp = 0;
  always @(posedge clk) begin
    int lim;
    if (!rstN) begin
      mCnt = 0; mBurst = 0; mStart = 0; mSusp = 0;
    end else begin
      lim = (outOn || mSusp) ? FAST : SLOW;
      mStart = 0;
      if (!mBurst) begin
        if (mCnt >= lim && !inhibit) begin
          mBurst = 1; mStart = 1;
        end else if (usTick && mCnt < lim) begin
          mCnt++;
        end
      end else if (burstDone) begin
        mBurst = 0; mCnt = 0;
      end
      if (touchDeny) mSusp = 0;
      else if (outOn) mSusp = 0;
      else if (maybeTouch || touchConfirm) mSusp = 1;
    end
  end

  // stimulus helpers driven at the falling edge
  int tickDiv = 0, sinceStart = 0;
  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % TDIV;
    usTick <= (tickDiv == 0);
    if (!rstN) sinceStart = 0;
    else if (burstStart) sinceStart = 1;
    else if (sinceStart > 0 && sinceStart < BLEN) sinceStart++;
    else sinceStart = 0;
    autoDone <= (sinceStart == BLEN);
  end

  // per-cycle comparison and phase length tracking
  bit prevCh = 0, prevXf = 0;
  int curLen = 0;
  logic [63:0] seenLen = '0;
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      chk(curReq, burstStart == mStart, burstStart, mStart);
      chk(curReq, (chargeEn || xferEn) == mBurst, chargeEn || xferEn, mBurst);
      chk("R8", !(chargeEn && xferEn), chargeEn && xferEn, 0);
      if (burstStart) chk("R8", chargeEn, chargeEn, 1);
      if ((chargeEn && prevCh) || (xferEn && prevXf)) begin
        curLen++;
      end else if ((xferEn && prevCh) || (chargeEn && prevXf)) begin
        chk("R9", curLen >= PH - DMAX && curLen <= PH + DMAX, curLen, PH);
        if (curLen < 64) seenLen[curLen] = 1'b1;
        curLen = 1;
      end else if (chargeEn || xferEn) begin
        curLen = 1;
      end
      prevCh = chargeEn; prevXf = xferEn;
    end
    if (cyc > WDOG && !finished) begin
      finished = 1;
      chk("watchdog", 0, cyc, WDOG);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic waitStarts(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!burstStart);
    end
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (chargeEn || xferEn);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  initial begin
    int seen;
    repeat (5) @(negedge clk);
    chk("R1", !burstStart && !chargeEn && !xferEn, {burstStart, chargeEn, xferEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", !burstStart && !chargeEn && !xferEn, {burstStart, chargeEn, xferEn}, 0);

    curReq = "R3"; waitStarts(3);

    curReq = "R2"; outOn = 1'b1; waitStarts(3);

    curReq = "R4"; outOn = 1'b0; waitStarts(1); waitIdle();
    repeat (8) @(negedge clk);
    pulse(maybeTouch); waitStarts(2);

    curReq = "R5"; pulse(touchDeny); waitStarts(2);

    curReq = "R6"; pulse(maybeTouch); waitStarts(1);
    pulse(touchConfirm); waitStarts(2);
    outOn = 1'b1; waitStarts(2);

    curReq = "R7"; waitIdle(); inhibit = 1'b1;
    seen = 0;
    repeat (60) begin @(negedge clk); if (burstStart) seen++; end
    chk("R7", seen == 0, seen, 0);
    inhibit = 1'b0; waitStarts(1);

    curReq = "R10"; outOn = 1'b0; waitIdle();
    repeat (3) @(negedge clk);
    pulse(extraDone);
    repeat (5) @(negedge clk);
    pulse(extraDone);
    waitStarts(1); waitIdle();

    chk("R9", $countones(seenLen) >= 2, $countones(seenLen), 2);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule